// File: doc/BRIEF.md
# Single-Voice ADSR Envelope Generator

This block produces the 8-bit amplitude envelope of one synthesizer voice. Software programs two timing bytes and a control byte through a simple write port. Setting the gate bit starts a rise toward full scale. The envelope then falls to a programmable hold level, and once the gate is cleared it falls to silence. The envelope value is presented on every clock.

Timing comes from a free-running 15-bit rate counter. When the counter reaches the period selected by the active phase, it issues a tick. In the falling phases a second, level-dependent divider thins those ticks to give an approximately exponential curve. Two hardware quirks are reproduced on purpose, and both can be seen at cycle level. First, if the rise is retriggered while the envelope is already at full scale, the envelope wraps to zero. Second, if a period is programmed below the counter's current value, the compare is missed and the counter has to wrap all the way round before the next tick.

Top module: `adsr_env`

## Requirements
- R1: A write with `wr_en` high is captured on the rising clock edge. The write goes to one of three registers: address 0 holds the rise rate in bits 7:4 and the fall rate in bits 3:0. Address 1 holds the hold level in bits 7:4 and the release rate in bits 3:0. Address 2 holds the gate in bit 0. A write to address 3 changes nothing.
- R2: While `rst` is high, the envelope is 0, the generator is in release and all three registers are cleared.
- R3: A 0-to-1 change of the gate starts the rise phase. On each step of that phase the envelope goes up by exactly 1. With rise rate 0, steps come exactly 9 clocks apart.
- R4: The 15-bit rate counter advances once per clock. A tick is issued, and the counter is cleared, on the clock where its incremented value equals the period for the active phase's rate nibble. The periods for nibbles 0 to 15 are 9, 32, 63, 95, 149, 220, 267, 313, 392, 977, 1954, 3126, 3907, 11720, 19532 and 31251 clocks. A larger period written while the counter is below it takes effect at once.
- R5: When a rise step brings the envelope to 0xFF, the phase becomes decay. Decay steps the envelope down by 1 until it equals the hold nibble times 0x11, and then holds it there.
- R6: A 1-to-0 change of the gate enters release from any phase. Release steps the envelope down by 1 and stops at 0.
- R7: In decay and release, one envelope step occurs every N ticks. N is 1 for envelope values above 93, 2 for 55..93, 4 for 27..54, 8 for 15..26, 16 for 7..14 and 30 for 0..6.
- R8: If the rise phase is re-entered while the envelope is 0xFF, its next step gives 0x00, and rising then continues from there.
- R9: If the active period is lowered below the counter's current value, no tick occurs until the counter passes 0x7FFF, wraps to 0 and counts up to the new period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register select |
| wr_data | input | 8 | Write data |
| env_out | output | 8 | Current envelope value |

## Verification
The bench attacks the two quirks directly. It retriggers the rise on the exact clock after full scale is reached, where a saturating design would stay at 0xFF. It also lowers the rise rate long after the counter has passed it, where a design that compares with "greater or equal" would step within 9 clocks instead of about 32,700. It measures the fall interval at six envelope levels spread across every divider band, so a band edge that is off by one, or a wrong divide ratio, shows up as a wrong interval. The decay check confirms that the envelope parks at the hold level, the release check confirms that it parks at 0, and a write to the unused address must not start a rise.

// File: rtl/adsr_env_pkg.sv
package adsr_env_pkg;

   localparam int ENV_W = 8;

   typedef enum logic [1:0] {
      PH_ATTACK  = 2'd0,
      PH_DECAY   = 2'd1,
      PH_RELEASE = 2'd2
   } phase_e;

   // clocks between ticks for each rate nibble
   function automatic logic [14:0] rate_period(input logic [3:0] nib);
      case (nib)
         4'd0:    rate_period = 15'd9;
         4'd1:    rate_period = 15'd32;
         4'd2:    rate_period = 15'd63;
         4'd3:    rate_period = 15'd95;
         4'd4:    rate_period = 15'd149;
         4'd5:    rate_period = 15'd220;
         4'd6:    rate_period = 15'd267;
         4'd7:    rate_period = 15'd313;
         4'd8:    rate_period = 15'd392;
         4'd9:    rate_period = 15'd977;
         4'd10:   rate_period = 15'd1954;
         4'd11:   rate_period = 15'd3126;
         4'd12:   rate_period = 15'd3907;
         4'd13:   rate_period = 15'd11720;
         4'd14:   rate_period = 15'd19532;
         default: rate_period = 15'd31251;
      endcase
   endfunction

   // ticks per envelope step in the falling phases
   function automatic logic [4:0] fall_ratio(input logic [ENV_W-1:0] lvl);
      if (lvl > 8'd93)      fall_ratio = 5'd1;
      else if (lvl >= 8'd55) fall_ratio = 5'd2;
      else if (lvl >= 8'd27) fall_ratio = 5'd4;
      else if (lvl >= 8'd15) fall_ratio = 5'd8;
      else if (lvl >= 8'd7)  fall_ratio = 5'd16;
      else                   fall_ratio = 5'd30;
   endfunction

endpackage

// File: rtl/adsr_env_regs.sv
module adsr_env_regs
   import adsr_env_pkg::*;
#(
   parameter int ADDR_W = 2
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [ENV_W-1:0]  wr_data,
   output logic [ENV_W-1:0]  tim_q,
   output logic [ENV_W-1:0]  lvl_q,
   output logic              gate_q,
   output logic              ctl_wr,
   output logic              gate_rise,
   output logic              gate_fall
);

   localparam logic [ADDR_W-1:0] A_TIM = ADDR_W'(0);
   localparam logic [ADDR_W-1:0] A_LVL = ADDR_W'(1);
   localparam logic [ADDR_W-1:0] A_CTL = ADDR_W'(2);

   if (ADDR_W < 2) begin : g_addr_chk
      $error("adsr_env_regs: ADDR_W must be at least 2");
   end

   assign ctl_wr    = wr_en && (wr_addr == A_CTL);
   assign gate_rise = ctl_wr &&  wr_data[0] && !gate_q;
   assign gate_fall = ctl_wr && !wr_data[0] &&  gate_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         tim_q  <= '0;
         lvl_q  <= '0;
         gate_q <= 1'b0;
      end else if (wr_en) begin
         if (wr_addr == A_TIM) tim_q  <= wr_data;
         if (wr_addr == A_LVL) lvl_q  <= wr_data;
         if (wr_addr == A_CTL) gate_q <= wr_data[0];
      end
   end

endmodule

// File: rtl/adsr_env_rate.sv
module adsr_env_rate #(
   parameter int RC_W = 15
) (
   input  logic            clk,
   input  logic            rst,
   input  logic [RC_W-1:0] period,
   output logic            tick
);

   logic [RC_W-1:0] cnt_q;
   logic [RC_W-1:0] cnt_inc;

   if (RC_W < 15) begin : g_width_chk
      $error("adsr_env_rate: RC_W below 15 cannot hold the longest period");
   end

   // equality compare only: a period below the count is missed until wrap
   assign cnt_inc = cnt_q + RC_W'(1);
   assign tick    = (cnt_inc == period);

   always_ff @(posedge clk) begin
      if (rst)       cnt_q <= '0;
      else if (tick) cnt_q <= '0;
      else           cnt_q <= cnt_inc;
   end

endmodule

// File: rtl/adsr_env_fall.sv
module adsr_env_fall
   import adsr_env_pkg::*;
#(
   parameter bit SHAPE_EN = 1'b1
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             tick,
   input  logic             bypass,
   input  logic [ENV_W-1:0] env,
   output logic             step
);

   if (SHAPE_EN) begin : g_shaped
      logic [4:0] div_q;
      logic [4:0] ratio;
      logic       roll;

      assign ratio = fall_ratio(env);
      assign roll  = bypass || ((div_q + 5'd1) >= ratio);
      assign step  = tick && roll;

      always_ff @(posedge clk) begin
         if (rst)                div_q <= '0;
         else if (tick && roll)  div_q <= '0;
         else if (tick)          div_q <= div_q + 5'd1;
      end
   end else begin : g_linear
      assign step = tick;
   end

endmodule

// File: rtl/adsr_env.sv
module adsr_env
   import adsr_env_pkg::*;
#(
   parameter int RC_W     = 15,
   parameter bit SHAPE_EN = 1'b1
) (
   input  logic        clk,
   input  logic        rst,
   input  logic        wr_en,
   input  logic [1:0]  wr_addr,
   input  logic [7:0]  wr_data,
   output logic [7:0]  env_out
);

   localparam logic [ENV_W-1:0] ENV_TOP = '1;

   logic [ENV_W-1:0] tim_q, lvl_q;
   logic             gate_q, ctl_wr, gate_rise, gate_fall;
   logic             tick, step;
   logic [RC_W-1:0]  period;
   logic [3:0]       nib;
   logic [ENV_W-1:0] env_q, env_d, hold_lvl;
   phase_e           phase_q, phase_d;

   adsr_env_regs #(.ADDR_W(2)) u_regs (
      .clk       (clk),
      .rst       (rst),
      .wr_en     (wr_en),
      .wr_addr   (wr_addr),
      .wr_data   (wr_data),
      .tim_q     (tim_q),
      .lvl_q     (lvl_q),
      .gate_q    (gate_q),
      .ctl_wr    (ctl_wr),
      .gate_rise (gate_rise),
      .gate_fall (gate_fall)
   );

   always_comb begin
      case (phase_q)
         PH_ATTACK: nib = tim_q[7:4];
         PH_DECAY:  nib = tim_q[3:0];
         default:   nib = lvl_q[3:0];
      endcase
   end

   assign period   = RC_W'(rate_period(nib));
   assign hold_lvl = {lvl_q[7:4], lvl_q[7:4]};

   adsr_env_rate #(.RC_W(RC_W)) u_rate (
      .clk    (clk),
      .rst    (rst),
      .period (period),
      .tick   (tick)
   );

   adsr_env_fall #(.SHAPE_EN(SHAPE_EN)) u_fall (
      .clk    (clk),
      .rst    (rst),
      .tick   (tick),
      .bypass (phase_q == PH_ATTACK),
      .env    (env_q),
      .step   (step)
   );

   always_comb begin
      env_d   = env_q;
      phase_d = phase_q;
      if (step) begin
         case (phase_q)
            PH_ATTACK: begin
               env_d = env_q + 8'd1;          // 0xFF wraps to 0x00
               if (env_d == ENV_TOP) phase_d = PH_DECAY;
            end
            PH_DECAY:   if (env_q != hold_lvl) env_d = env_q - 8'd1;
            default:    if (env_q != '0)       env_d = env_q - 8'd1;
         endcase
      end
      if (gate_rise) phase_d = PH_ATTACK;
      if (gate_fall) phase_d = PH_RELEASE;
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         env_q   <= '0;
         phase_q <= PH_RELEASE;
      end else begin
         env_q   <= env_d;
         phase_q <= phase_d;
      end
   end

   assign env_out = env_q;

   // R3: the envelope only ever moves by one count (modulo 256)
   p_unit_step_r3: assert property (@(posedge clk) disable iff (rst)
      (env_q != $past(env_q)) |->
         ((env_q == $past(env_q) + 8'd1) || (env_q == $past(env_q) - 8'd1)));

   // R4: any envelope movement is preceded by a rate tick
   p_step_needs_tick_r4: assert property (@(posedge clk) disable iff (rst)
      (env_q != $past(env_q)) |-> $past(tick));

   // R5: reaching full scale in the rise moves to decay
   p_rise_to_decay_r5: assert property (@(posedge clk) disable iff (rst)
      ($past(phase_q == PH_ATTACK) && $past(env_q) == 8'hFE &&
       env_q == 8'hFF && !$past(ctl_wr)) |-> (phase_q == PH_DECAY));

   // R5: decay parks at the hold level
   p_sustain_hold_r5: assert property (@(posedge clk) disable iff (rst)
      ($past(phase_q == PH_DECAY) && phase_q == PH_DECAY &&
       $past(env_q) == $past(hold_lvl) && hold_lvl == $past(hold_lvl))
      |-> (env_q == hold_lvl));

   // R6: a falling gate always lands in release
   p_gate_fall_release_r6: assert property (@(posedge clk) disable iff (rst)
      $past(gate_fall) |-> (phase_q == PH_RELEASE));

   // R6: release does not go below zero
   p_release_floor_r6: assert property (@(posedge clk) disable iff (rst)
      ($past(phase_q == PH_RELEASE) && phase_q == PH_RELEASE &&
       $past(env_q) == 8'd0) |-> (env_q == 8'd0));

endmodule

// File: tb/adsr_env_tb_top.sv
`timescale 1ns/1ps
module adsr_env_tb_top;

   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic       wr_en = 1'b0;
   logic [1:0] wr_addr = '0;
   logic [7:0] wr_data = '0;
   logic [7:0] env_out;

   int errs = 0;
   int checks = 0;

   always #10 clk = ~clk;   // 50 MHz

   adsr_env dut_i (
      .clk     (clk),
      .rst     (rst),
      .wr_en   (wr_en),
      .wr_addr (wr_addr),
      .wr_data (wr_data),
      .env_out (env_out)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errs++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic do_reset();
      rst = 1'b1;
      repeat (3) @(negedge clk);
      rst = 1'b0;
   endtask

   task automatic wr(input logic [1:0] a, input logic [7:0] d);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   // clocks until env_out differs from its value now
   task automatic wait_change(output int n, input int limit);
      logic [7:0] v;
      v = env_out;
      n = 0;
      do begin
         @(negedge clk);
         n++;
      end while (env_out == v && n < limit);
   endtask

   task automatic wait_level(input logic [7:0] l, input int limit, output bit found);
      int k;
      k = 0;
      while (env_out != l && k < limit) begin
         @(negedge clk);
         k++;
      end
      found = (env_out == l);
   endtask

   task automatic t_reset();
      do_reset();
      chk(env_out == 8'd0, "R2 reset envelope", env_out, 0);
      wr(2'd3, 8'h01);
      repeat (50) @(negedge clk);
      chk(env_out == 8'd0, "R1 address 3 write ignored", env_out, 0);
   endtask

   task automatic t_rise_and_wrap();
      int n; bit f;
      do_reset();
      wr(2'd1, 8'hF0);
      wr(2'd2, 8'h01);
      wait_change(n, 20);
      chk(env_out == 8'd1, "R3 first rise step", env_out, 1);
      wait_change(n, 20);
      chk(n == 9, "R3 rate 0 interval", n, 9);
      chk(env_out == 8'd2, "R3 step by one", env_out, 2);
      wait_level(8'hFF, 3000, f);
      chk(f, "R3 reaches full scale", env_out, 255);
      wr(2'd2, 8'h00);
      wr(2'd2, 8'h01);
      wait_change(n, 20);
      chk(env_out == 8'h00, "R8 retrigger at 0xFF wraps", env_out, 0);
      chk(n == 7, "R8 wrap on next tick", n, 7);
      wait_change(n, 20);
      chk(env_out == 8'h01 && n == 9, "R8 rise continues after wrap", env_out, 1);
   endtask

   task automatic t_decay_release();
      int n; bit f;
      int lv[6] = '{100, 60, 40, 20, 10, 3};
      int ex[6] = '{9, 18, 36, 72, 144, 270};
      do_reset();
      wr(2'd1, 8'h80);
      wr(2'd2, 8'h01);
      wait_level(8'hFF, 3000, f);
      chk(f, "R5 peak reached", env_out, 255);
      wait_change(n, 20);
      chk(env_out == 8'hFE && n == 9, "R5 decay begins", env_out, 254);
      repeat (1200) @(negedge clk);
      chk(env_out == 8'h88, "R5 decay reaches hold level", env_out, 136);
      repeat (300) @(negedge clk);
      chk(env_out == 8'h88, "R5 hold level kept", env_out, 136);
      wr(2'd2, 8'h00);
      wait_change(n, 20);
      chk(env_out == 8'h87, "R6 release from decay", env_out, 135);
      for (int i = 0; i < 6; i++) begin
         wait_level(8'(lv[i]), 10000, f);
         wait_change(n, 1000);
         chk(f && n == ex[i], "R7 fall interval", n, ex[i]);
      end
      wait_level(8'h00, 5000, f);
      repeat (600) @(negedge clk);
      chk(env_out == 8'h00, "R6 release floor at 0", env_out, 0);
   endtask

   task automatic t_late_rate();
      int n;
      do_reset();
      wr(2'd0, 8'hF0);
      wr(2'd2, 8'h01);
      repeat (100) @(negedge clk);
      chk(env_out == 8'd0, "R4 slow rise rate", env_out, 0);
      wr(2'd0, 8'h00);
      wait_change(n, 40000);
      n = n + 1;
      chk(n >= 32500 && n <= 32790, "R9 late rate costs full wrap", n, 32677);
      chk(env_out == 8'd1, "R9 step after wrap", env_out, 1);
      wait_change(n, 20);
      chk(n == 9 && env_out == 8'd2, "R3 interval after wrap", n, 9);
      wr(2'd0, 8'h10);
      wait_change(n, 100);
      n = n + 1;
      chk(n == 32 && env_out == 8'd3, "R4 larger period applies", n, 32);
      wr(2'd2, 8'h00);
      wait_change(n, 400);
      chk(env_out == 8'd2, "R6 release from rise", env_out, 2);
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      errs++; checks++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
   end

   initial begin
      @(negedge clk);
      t_reset();
      t_rise_and_wrap();
      t_decay_release();
      t_late_rate();
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
   end

endmodule